// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a multi-function peripheral chip. It answers two byte-wide I/O addresses: an index port at a parameterised base address and a data port at the next address. The configuration space is locked after reset. Software opens it with two back-to-back writes of 0x55 to the index port and closes it with a write of 0xAA. While the space is open, software writes a register number to the index port and then reads or writes that register through the data port.

A few global registers hold the identity, the power enables and the logical-device selector. All registers from 0x30 upward are banked: each access reaches the bank of the logical device that the selector currently names. Each bank holds an enable flag, a 16-bit I/O base, an interrupt line and, on some devices only, a DMA channel, a second interrupt line or mode bytes. These values are driven as outputs to the peripheral functions, which are outside this block.

The unlock controller is a three-state machine:
- **ST_LOCKED**: goes to ST_HALF when 0x55 is written to the index port.
- **ST_HALF**: goes to ST_OPEN when 0x55 is written again, and back to ST_LOCKED when any other value is written to the index port.
- **ST_OPEN**: goes to ST_LOCKED when 0xAA is written to the index port. Any other index write loads the index register.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the space is locked, the index and the logical device number are 0, and every output is 0 (all devices inactive).
- R2: The space opens only after two consecutive 0x55 writes to the index port. An index write of any other value between them cancels the first key.
- R3: Writing 0xAA to the index port while the space is open locks it again. After that, data port reads return 0xFF.
- R4: While locked, data port writes change nothing, and reads of either port return 0xFF.
- R5: While open, reading the index port returns the last register number written to it.
- R6: Register 0x20 reads 0x02 and register 0x21 reads the revision parameter (default 0x01).
- R7: Register 0x07 holds the logical device number (0 floppy, 1 IDE1, 2 IDE2, 3 parallel, 4 serial1, 5 serial2, 6 RTC, 7 keyboard, 8 aux I/O) and reads back. Banked writes reach only the selected device.
- R8: Register 0x22 is a power-enable bitmap: bits 0..5 are read/write and drive `pwr_en`, and bits 6..7 read 0.
- R9: Banked register 0x30 bit 0 drives `dev_active[n]`. Registers 0x60 and 0x61 are the high and low bytes of `dev_base` slice n (bits n*16 +: 16). Register 0x70 bits 3:0 drive `dev_irq` slice n (n*4 +: 4).
- R10: Register 0x72 (4-bit, drives `kbd_irq2`) exists only on device 7. Register 0x74 (3-bit, drives `dev_dma` slice n*3 +: 3) exists only on devices 0 and 3.
- R11: On device 0 only, registers 0x90 (`fdc_mode`) and 0x91 (`fdc_opt`) hold full bytes, so a read-modify-write that sets bits 1..3 keeps the other bits.
- R12: Registers not implemented for the selected device, and every banked register when the device number is above 8, read 0x00 and ignore writes.
- R13: A data port write updates the matching output at the clock edge that samples the write.
- R14: Read data appears on `io_rdata` with `rd_valid` high in the cycle after the read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | io_rdata is valid |
| dev_active | output | 9 | Enable flag per logical device |
| dev_base | output | 144 | 16-bit I/O base per device |
| dev_irq | output | 36 | 4-bit interrupt per device |
| dev_dma | output | 27 | 3-bit DMA channel per device |
| kbd_irq2 | output | 4 | Keyboard second interrupt |
| fdc_mode | output | 8 | Floppy mode byte |
| fdc_opt | output | 8 | Floppy option byte |
| pwr_en | output | 6 | Power enable bitmap |

## Verification
The hardest cases to reach from the ports are the ones where nothing happens.

The cancelled unlock sequence needs a 0x55, then a different index value, then a single 0x55. Only the missing 0xFF at the data port shows whether the first key was dropped.

Writes to registers that a device lacks, and writes to a device number above 8, change no output. The bench first programs distinct values into the devices that do have those registers, then reads the unimplemented registers back and checks that every output stayed the same.

The locked-state data write is aimed at a device whose flag is already set. The bench then reopens the space and checks that the flag is still set.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int NDEV     = 9;
    localparam int BASE_W   = 16;
    localparam int IRQ_W    = 4;
    localparam int DMA_W    = 3;
    localparam int PWR_W    = 6;

    localparam logic [7:0] KEY_OPEN  = 8'h55;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;

    localparam logic [7:0] RG_LDN    = 8'h07;
    localparam logic [7:0] RG_ID     = 8'h20;
    localparam logic [7:0] RG_REV    = 8'h21;
    localparam logic [7:0] RG_PWR    = 8'h22;
    localparam logic [7:0] RG_ACT    = 8'h30;
    localparam logic [7:0] RG_BASEH  = 8'h60;
    localparam logic [7:0] RG_BASEL  = 8'h61;
    localparam logic [7:0] RG_IRQ    = 8'h70;
    localparam logic [7:0] RG_IRQ2   = 8'h72;
    localparam logic [7:0] RG_DMA    = 8'h74;
    localparam logic [7:0] RG_MODE   = 8'h90;
    localparam logic [7:0] RG_OPT    = 8'h91;
    localparam logic [7:0] BANK_LO   = 8'h30;

    localparam int DEV_FDC  = 0;
    localparam int DEV_PAR  = 3;
    localparam int DEV_KBD  = 7;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;
endpackage

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       idx_load
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cfg_open = 1'b0;
        idx_load = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_OPEN) state_d = ST_HALF;
            end
            ST_HALF: begin
                if (idx_wr) state_d = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
            end
            ST_OPEN: begin
                cfg_open = 1'b1;
                if (idx_wr) begin
                    if (wdata == KEY_CLOSE) state_d = ST_LOCKED;
                    else                    idx_load = 1'b1;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter bit HAS_IRQ2 = 1'b0,
    parameter bit HAS_DMA  = 1'b0,
    parameter bit HAS_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        index,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              act,
    output logic [BASE_W-1:0] base,
    output logic [IRQ_W-1:0]  irq,
    output logic [IRQ_W-1:0]  irq2,
    output logic [DMA_W-1:0]  dma,
    output logic [7:0]        mode,
    output logic [7:0]        opt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act  <= 1'b0;
            base <= '0;
            irq  <= '0;
        end else if (wr_en) begin
            if (index == RG_ACT)   act          <= wdata[0];
            if (index == RG_BASEH) base[15:8]   <= wdata;
            if (index == RG_BASEL) base[7:0]    <= wdata;
            if (index == RG_IRQ)   irq          <= wdata[IRQ_W-1:0];
        end
    end

    generate
        if (HAS_IRQ2) begin : g_irq2
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        irq2 <= '0;
                else if (wr_en && index == RG_IRQ2) irq2 <= wdata[IRQ_W-1:0];
            end
        end else begin : g_no_irq2
            assign irq2 = '0;
        end

        if (HAS_DMA) begin : g_dma
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       dma <= '0;
                else if (wr_en && index == RG_DMA) dma <= wdata[DMA_W-1:0];
            end
        end else begin : g_no_dma
            assign dma = '0;
        end

        if (HAS_MODE) begin : g_mode
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mode <= '0;
                    opt  <= '0;
                end else if (wr_en) begin
                    if (index == RG_MODE) mode <= wdata;
                    if (index == RG_OPT)  opt  <= wdata;
                end
            end
        end else begin : g_no_mode
            assign mode = '0;
            assign opt  = '0;
        end
    endgenerate

    always_comb begin
        rdata = 8'h00;
        unique case (index)
            RG_ACT:   rdata = {7'd0, act};
            RG_BASEH: rdata = base[15:8];
            RG_BASEL: rdata = base[7:0];
            RG_IRQ:   rdata = {{(8-IRQ_W){1'b0}}, irq};
            RG_IRQ2:  rdata = {{(8-IRQ_W){1'b0}}, irq2};
            RG_DMA:   rdata = {{(8-DMA_W){1'b0}}, dma};
            RG_MODE:  rdata = mode;
            RG_OPT:   rdata = opt;
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h03F0,
    parameter logic [7:0]  CHIP_ID   = 8'h02,
    parameter logic [7:0]  CHIP_REV  = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic                   rd_valid,
    output logic [NDEV-1:0]        dev_active,
    output logic [NDEV*BASE_W-1:0] dev_base,
    output logic [NDEV*IRQ_W-1:0]  dev_irq,
    output logic [NDEV*DMA_W-1:0]  dev_dma,
    output logic [IRQ_W-1:0]       kbd_irq2,
    output logic [7:0]             fdc_mode,
    output logic [7:0]             fdc_opt,
    output logic [PWR_W-1:0]       pwr_en
);
    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

    logic       idx_hit, data_hit, cfg_open, idx_load;
    logic [7:0] idx_q;
    logic [3:0] ldn_q;
    logic [7:0] rd_mux, bank_sel_rd;
    logic       glob_wr, bank_wr;
    logic [7:0]       bank_rd   [NDEV];
    logic [IRQ_W-1:0] bank_irq2 [NDEV];
    logic [7:0]       bank_mode [NDEV];
    logic [7:0]       bank_opt  [NDEV];

    assign idx_hit  = (io_addr == BASE_ADDR);
    assign data_hit = (io_addr == DATA_ADDR);

    cfgport_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && idx_hit),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    assign glob_wr = io_wr && data_hit && cfg_open && (idx_q < BANK_LO);
    assign bank_wr = io_wr && data_hit && cfg_open && (idx_q >= BANK_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ldn_q  <= '0;
            pwr_en <= '0;
        end else begin
            if (idx_load) idx_q <= io_wdata;
            if (glob_wr && idx_q == RG_LDN) ldn_q  <= io_wdata[3:0];
            if (glob_wr && idx_q == RG_PWR) pwr_en <= io_wdata[PWR_W-1:0];
        end
    end

    generate
        for (genvar i = 0; i < NDEV; i++) begin : g_dev
            cfgport_bank #(
                .HAS_IRQ2 (i == DEV_KBD),
                .HAS_DMA  (i == DEV_FDC || i == DEV_PAR),
                .HAS_MODE (i == DEV_FDC)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (bank_wr && (ldn_q == 4'(i))),
                .index (idx_q),
                .wdata (io_wdata),
                .rdata (bank_rd[i]),
                .act   (dev_active[i]),
                .base  (dev_base[i*BASE_W +: BASE_W]),
                .irq   (dev_irq[i*IRQ_W +: IRQ_W]),
                .irq2  (bank_irq2[i]),
                .dma   (dev_dma[i*DMA_W +: DMA_W]),
                .mode  (bank_mode[i]),
                .opt   (bank_opt[i])
            );
        end
    endgenerate

    assign kbd_irq2 = bank_irq2[DEV_KBD];
    assign fdc_mode = bank_mode[DEV_FDC];
    assign fdc_opt  = bank_opt[DEV_FDC];

    always_comb begin
        bank_sel_rd = 8'h00;
        for (int i = 0; i < NDEV; i++) begin
            if (ldn_q == 4'(i)) bank_sel_rd = bank_rd[i];
        end
    end

    always_comb begin
        if (!cfg_open)    rd_mux = 8'hFF;
        else if (idx_hit) rd_mux = idx_q;
        else begin
            unique case (idx_q)
                RG_LDN:  rd_mux = {4'd0, ldn_q};
                RG_ID:   rd_mux = CHIP_ID;
                RG_REV:  rd_mux = CHIP_REV;
                RG_PWR:  rd_mux = {{(8-PWR_W){1'b0}}, pwr_en};
                default: rd_mux = (idx_q >= BANK_LO) ? bank_sel_rd : 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rdata <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= io_rd && (idx_hit || data_hit);
            if (io_rd && (idx_hit || data_hit)) io_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk
    import cfgport_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h03F0,
    parameter logic [7:0]  CHIP_ID   = 8'h02
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [15:0]            io_addr,
    input logic                   io_wr,
    input logic                   io_rd,
    input logic [7:0]             io_wdata,
    input logic [7:0]             io_rdata,
    input logic                   rd_valid,
    input logic [NDEV-1:0]        dev_active,
    input logic [NDEV*BASE_W-1:0] dev_base,
    input logic                   cfg_open,
    input logic [7:0]             idx_q
);
    logic ih, dh;
    assign ih = (io_addr == BASE_ADDR);
    assign dh = (io_addr == BASE_ADDR + 16'd1);

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && ih && io_wdata == KEY_OPEN));

    p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && ih && io_wdata == KEY_CLOSE) |=> !cfg_open);

    p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && (ih || dh)) |=> (io_rdata == 8'hFF));

    p_locked_write_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && dh) |=> ($stable(dev_active) && $stable(dev_base)));

    p_chip_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_rd && dh && idx_q == RG_ID) |=> (io_rdata == CHIP_ID));

    p_rd_latency_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (ih || dh)) |=> rd_valid);
endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(.BASE_ADDR(BASE_ADDR), .CHIP_ID(CHIP_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .rd_valid   (rd_valid),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .cfg_open   (cfg_open),
    .idx_q      (idx_q)
);

// File: tb/cfgport_ctrl_tb.sv
module cfgport_ctrl_tb;
    import cfgport_pkg::*;

    localparam logic [15:0] IDXP = 16'h03F0;
    localparam logic [15:0] DATP = 16'h03F1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic rd_valid;
    logic [NDEV-1:0] dev_active;
    logic [NDEV*BASE_W-1:0] dev_base;
    logic [NDEV*IRQ_W-1:0] dev_irq;
    logic [NDEV*DMA_W-1:0] dev_dma;
    logic [IRQ_W-1:0] kbd_irq2;
    logic [7:0] fdc_mode, fdc_opt;
    logic [PWR_W-1:0] pwr_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    cfgport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .rd_valid(rd_valid),
        .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
        .dev_dma(dev_dma), .kbd_irq2(kbd_irq2), .fdc_mode(fdc_mode),
        .fdc_opt(fdc_opt), .pwr_en(pwr_en)
    );

    task automatic check(string req, logic [159:0] act, logic [159:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] r, logic [7:0] d);
        wr(IDXP, r);
        wr(DATP, d);
    endtask

    task automatic reg_rd(logic [7:0] r, logic [7:0] exp, string req);
        wr(IDXP, r);
        rd(DATP, exp, req);
    endtask

    // monitor: R14 read data one cycle after strobe
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R14 unexpected read actual=%0h expected=none", io_rdata);
            end else begin
                check(tag_q.pop_front(), 160'(io_rdata), 160'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 active", 160'(dev_active), 160'(0));
        check("R1 base", 160'(dev_base), 160'(0));
        check("R1 pwr", 160'(pwr_en), 160'(0));
        // R4 locked reads
        rd(IDXP, 8'hFF, "R4 idx locked");
        rd(DATP, 8'hFF, "R4 data locked");
        // R2 cancelled key
        wr(IDXP, 8'h55); wr(IDXP, 8'h20); wr(IDXP, 8'h55);
        rd(DATP, 8'hFF, "R2 cancelled key");
        wr(IDXP, 8'h55);
        rd(IDXP, 8'h00, "R2 open idx reset 0");
        // R5, R6
        wr(IDXP, 8'h20);
        rd(IDXP, 8'h20, "R5 idx readback");
        rd(DATP, 8'h02, "R6 id");
        reg_rd(8'h21, 8'h01, "R6 rev");
        // R7, R9, R13
        reg_wr(8'h07, 8'h04);
        reg_rd(8'h07, 8'h04, "R7 ldn");
        reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8); reg_wr(8'h70, 8'h04);
        reg_wr(8'h30, 8'h01);
        check("R13 active dev4", 160'(dev_active), 160'(9'h010));
        check("R9 base dev4", 160'(dev_base[4*16 +: 16]), 160'(16'h03F8));
        check("R9 irq dev4", 160'(dev_irq[4*4 +: 4]), 160'(4'h4));
        reg_wr(8'h07, 8'h05);
        reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'hF8); reg_wr(8'h70, 8'h03);
        reg_rd(8'h61, 8'hF8, "R9 readback");
        check("R7 dev4 kept", 160'(dev_base[4*16 +: 16]), 160'(16'h03F8));
        check("R7 dev5 base", 160'(dev_base[5*16 +: 16]), 160'(16'h02F8));
        check("R7 dev5 inactive", 160'(dev_active), 160'(9'h010));
        // R10
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h74, 8'h02);
        reg_rd(8'h74, 8'h02, "R10 dma par");
        reg_wr(8'h72, 8'h0C);
        reg_rd(8'h72, 8'h00, "R10 irq2 absent par");
        check("R10 kbd irq2 untouched", 160'(kbd_irq2), 160'(0));
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h72, 8'h0C);
        reg_rd(8'h72, 8'h0C, "R10 irq2 kbd");
        check("R10 kbd_irq2", 160'(kbd_irq2), 160'(4'hC));
        reg_wr(8'h74, 8'h03);
        reg_rd(8'h74, 8'h00, "R10 dma absent kbd");
        check("R10 dma map", 160'(dev_dma), 160'(27'(3'd2) << 9));
        // R11
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h90, 8'h40);
        reg_rd(8'h90, 8'h40, "R11 mode");
        reg_wr(8'h90, 8'h40 | 8'h0E);
        reg_rd(8'h90, 8'h4E, "R11 rmw");
        check("R11 fdc_mode", 160'(fdc_mode), 160'(8'h4E));
        reg_wr(8'h91, 8'hA5);
        check("R11 fdc_opt", 160'(fdc_opt), 160'(8'hA5));
        reg_wr(8'h07, 8'h01);
        reg_wr(8'h90, 8'h11);
        reg_rd(8'h90, 8'h00, "R11 mode absent dev1");
        check("R11 fdc_mode kept", 160'(fdc_mode), 160'(8'h4E));
        // R8
        reg_wr(8'h22, 8'hFF);
        reg_rd(8'h22, 8'h3F, "R8 pwr");
        check("R8 pwr_en", 160'(pwr_en), 160'(6'h3F));
        // R12
        reg_wr(8'h40, 8'h77);
        reg_rd(8'h40, 8'h00, "R12 unimpl");
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h01);
        reg_rd(8'h30, 8'h00, "R12 ldn9");
        check("R12 active kept", 160'(dev_active), 160'(9'h010));
        // R3, R4
        reg_wr(8'h07, 8'h04);
        wr(IDXP, 8'h30);
        wr(IDXP, 8'hAA);
        rd(DATP, 8'hFF, "R3 closed");
        wr(DATP, 8'h00);
        check("R4 locked write", 160'(dev_active), 160'(9'h010));
        wr(IDXP, 8'h55); wr(IDXP, 8'h55);
        reg_rd(8'h30, 8'h01, "R4 flag kept");
        repeat (3) @(negedge clk);
        check("R14 queue drained", 160'(exp_q.size()), 160'(0));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule